// File: doc/BRIEF.md
# Per-Core Reset Controller

This block lets any bus master on a multi-core chip put one core into reset and take it out again, without touching the other cores. Each core has a reset request bit and an interface-disable bit, both written by software. Two status registers can be read back. One shows whether each core's reset output has taken effect. The other shows whether each core's interfaces are shut and its outstanding transactions have drained. The drain is reported by a per-core busy input from the interconnect.

Software resets a core in this order:
1. Clear that core's reset status bit.
2. Set its interface-disable bit.
3. Wait for its drained bit.
4. Set its reset bit and wait for the reset status bit.
5. Re-enable the interfaces.
6. Clear the reset bit and wait for the status bit to drop.

A write-once lock freezes the control registers until the next system reset. Bad accesses set sticky error flags, and these flags drive an interrupt.

The register bus uses word addresses. Writes take effect at the clock edge that samples them. Read data is returned one cycle after the read request.

Top module: `core_rst_ctl`

## Requirements
- R1: An accepted write to word 0 (reset control, bit n for core n) sets core_rst[n] to bit n of the write data, one clock edge after the edge that samples the write.
- R2: Bit n of word 1 (reset status) takes the value of core_rst[n] at the edge after core_rst[n] changes, and otherwise holds. Writing 1 to a status bit clears it.
- R3: An accepted write to word 2 (interface disable) drives core_if_off at the same edge that samples the write.
- R4: Bit n of word 3 (drained status, read-only) is updated every cycle to core_if_off[n] AND NOT core_busy[n], one edge after the inputs.
- R5: Clearing an interface-disable bit while its core is held in reset re-enables the interfaces and leaves core_rst unchanged.
- R6: Any of the following sets the address-error flag (word 5, bit 1) and changes no register: a write to word 3, or any read or write to words 6 and above. Reads of those reserved words return 0.
- R7: Bit 0 of word 4 (lock) is write-once. While it is 1, writes to words 0, 2 and 4 set the write-error flag (word 5, bit 0) and leave those registers unchanged. Only reset clears the lock.
- R8: The error flags are sticky and cleared by writing 1 to them, and err_irq is the OR of the two flags.
- R9: Read data appears on bus_rdata one cycle after the read. Bits at or above NCORE read as 0, and written values in those bits are discarded.
- R10: After reset, core_rst, core_if_off, err_irq, the lock bit and all status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid one cycle after the read |
| core_busy | input | NCORE | Per-core outstanding-transaction indication |
| core_rst | output | NCORE | Per-core reset output |
| core_if_off | output | NCORE | Per-core interface disable |
| err_irq | output | 1 | Error interrupt |

## Verification
The following results fall due at the edge that samples a write: the interface-disable output, the lock bit and the error flags. The reset output follows one edge later, and the reset status one edge after that. The drained status lags the busy input by one edge, and read data lags the read by one edge. Every bus operation in the bench starts and ends on a falling edge, and the bench inserts exactly the number of falling edges each result needs before sampling. Some reads are placed deliberately one edge early so that they must return the old status, which checks the latency directly.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned OFS_CTRL  = 0;
  localparam int unsigned OFS_STAT  = 1;
  localparam int unsigned OFS_DIS   = 2;
  localparam int unsigned OFS_DRAIN = 3;
  localparam int unsigned OFS_LOCK  = 4;
  localparam int unsigned OFS_ERR   = 5;
  localparam int unsigned ERR_WR    = 0;
  localparam int unsigned ERR_ADR   = 1;
endpackage

// File: rtl/crc_core_slice.sv
module crc_core_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic dis,
  input  logic busy,
  input  logic stat_clr,
  output logic rst_o,
  output logic stat_o,
  output logic drain_o
);
  logic rst_q, prev_q, stat_q, drain_q;
  logic stat_d, drain_d, changed;

  always_comb begin
    changed = rst_q ^ prev_q;
    if (changed)       stat_d = rst_q;
    else if (stat_clr) stat_d = 1'b0;
    else               stat_d = stat_q;
    drain_d = dis & ~busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q   <= 1'b0;
      prev_q  <= 1'b0;
      stat_q  <= 1'b0;
      drain_q <= 1'b0;
    end else begin
      rst_q   <= req;
      prev_q  <= rst_q;
      stat_q  <= stat_d;
      drain_q <= drain_d;
    end
  end

  assign rst_o   = rst_q;
  assign stat_o  = stat_q;
  assign drain_o = drain_q;
endmodule

// File: rtl/crc_regs.sv
module crc_regs
  import crc_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [NCORE-1:0] stat_in,
  input  logic [NCORE-1:0] drain_in,
  output logic [NCORE-1:0] ctrl_q,
  output logic [NCORE-1:0] dis_q,
  output logic [NCORE-1:0] stat_clr,
  output logic             lock_q,
  output logic [1:0]       err_q,
  output logic [DW-1:0]    rdata
);
  logic is_ctrl, is_stat, is_dis, is_drain, is_lock, is_err, is_rsvd;
  logic wr_go, rd_go, guarded, wr_err, adr_err;
  logic [NCORE-1:0] ctrl_d, dis_d;
  logic             lock_d;
  logic [1:0]       err_d, err_w1c;
  logic [DW-1:0]    rdata_d;
  logic             unused_wbits;

  assign unused_wbits = ^wdata;

  always_comb begin
    is_ctrl  = (addr == AW'(OFS_CTRL));
    is_stat  = (addr == AW'(OFS_STAT));
    is_dis   = (addr == AW'(OFS_DIS));
    is_drain = (addr == AW'(OFS_DRAIN));
    is_lock  = (addr == AW'(OFS_LOCK));
    is_err   = (addr == AW'(OFS_ERR));
    is_rsvd  = (addr > AW'(OFS_ERR));
    wr_go    = sel & wr;
    rd_go    = sel & ~wr;
    guarded  = is_ctrl | is_dis | is_lock;
    wr_err   = wr_go & lock_q & guarded;
    adr_err  = sel & (is_rsvd | (wr & is_drain));

    ctrl_d = (wr_go & is_ctrl & ~lock_q) ? wdata[NCORE-1:0] : ctrl_q;
    dis_d  = (wr_go & is_dis  & ~lock_q) ? wdata[NCORE-1:0] : dis_q;
    lock_d = lock_q | (wr_go & is_lock & wdata[0]);

    err_w1c = (wr_go & is_err) ? wdata[1:0] : 2'b00;
    err_d   = err_q & ~err_w1c;
    err_d[ERR_WR]  = err_d[ERR_WR]  | wr_err;
    err_d[ERR_ADR] = err_d[ERR_ADR] | adr_err;

    stat_clr = (wr_go & is_stat) ? wdata[NCORE-1:0] : '0;

    rdata_d = rdata;
    if (rd_go) begin
      rdata_d = '0;
      if (is_ctrl)  rdata_d = DW'(ctrl_q);
      if (is_stat)  rdata_d = DW'(stat_in);
      if (is_dis)   rdata_d = DW'(dis_q);
      if (is_drain) rdata_d = DW'(drain_in);
      if (is_lock)  rdata_d = DW'(lock_q);
      if (is_err)   rdata_d = DW'(err_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dis_q  <= '0;
      lock_q <= 1'b0;
      err_q  <= '0;
      rdata  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      dis_q  <= dis_d;
      lock_q <= lock_d;
      err_q  <= err_d;
      rdata  <= rdata_d;
    end
  end
endmodule

// File: rtl/core_rst_ctl.sv
module core_rst_ctl #(
  parameter int NCORE = 4,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NCORE-1:0] core_busy,
  output logic [NCORE-1:0] core_rst,
  output logic [NCORE-1:0] core_if_off,
  output logic             err_irq
);
  logic [1:0]       sync_q;
  logic             rst_sync_n;
  logic [NCORE-1:0] ctrl_q, dis_q, stat_clr, stat_q, drain_q;
  logic             lock_q;
  logic [1:0]       err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  crc_regs #(.NCORE(NCORE), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .sel(bus_sel), .wr(bus_wr),
    .addr(bus_addr), .wdata(bus_wdata), .stat_in(stat_q), .drain_in(drain_q),
    .ctrl_q(ctrl_q), .dis_q(dis_q), .stat_clr(stat_clr), .lock_q(lock_q),
    .err_q(err_q), .rdata(bus_rdata)
  );

  for (genvar n = 0; n < NCORE; n++) begin : g_core
    crc_core_slice u_slice (
      .clk(clk), .rst_n(rst_sync_n), .req(ctrl_q[n]), .dis(dis_q[n]),
      .busy(core_busy[n]), .stat_clr(stat_clr[n]), .rst_o(core_rst[n]),
      .stat_o(stat_q[n]), .drain_o(drain_q[n])
    );
  end

  assign core_if_off = dis_q;
  assign err_irq     = |err_q;
endmodule

// File: rtl/crc_chk.sv
module crc_chk #(
  parameter int NCORE = 4,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             wr,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wdata,
  input logic [NCORE-1:0] core_rst,
  input logic [NCORE-1:0] core_if_off,
  input logic [NCORE-1:0] core_busy,
  input logic             err_irq,
  input logic             lock_q,
  input logic [NCORE-1:0] stat_q,
  input logic [NCORE-1:0] drain_q
);
  // R1
  rst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == AW'(0) && !lock_q) |=> ##1 (core_rst == $past(wdata[NCORE-1:0], 2)));
  // R2
  stat_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst != $past(core_rst)) |=> (stat_q == $past(core_rst)));
  // R4
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drain_q == $past(core_if_off & ~core_busy)));
  // R6
  rsvd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && addr > AW'(5)) |=> err_irq);
  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R7
  lock_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && sel && wr && addr == AW'(2)) |=> $stable(core_if_off));
endmodule

bind core_rst_ctl crc_chk #(.NCORE(NCORE), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
  .wdata(bus_wdata), .core_rst(core_rst), .core_if_off(core_if_off),
  .core_busy(core_busy), .err_irq(err_irq), .lock_q(lock_q),
  .stat_q(stat_q), .drain_q(drain_q)
);

// File: tb/sim_core_rst_ctl.sv
`timescale 1ns/1ps
module sim_core_rst_ctl;
  localparam int NCORE = 4;
  localparam int AW    = 4;
  localparam int DW    = 32;

  logic             clk;
  logic             rst_n;
  logic             bus_sel, bus_wr;
  logic [AW-1:0]    bus_addr;
  logic [DW-1:0]    bus_wdata, bus_rdata;
  logic [NCORE-1:0] core_busy, core_rst, core_if_off;
  logic             err_irq;
  int checks = 0;
  int errors = 0;

  core_rst_ctl #(.NCORE(NCORE), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_busy(core_busy), .core_rst(core_rst), .core_if_off(core_if_off),
    .err_irq(err_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the sampling edge.
  task automatic bus_write(input int a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R10 core_rst", 32'(core_rst), 0);
    chk("R10 core_if_off", 32'(core_if_off), 0);
    chk("R10 err_irq", 32'(err_irq), 0);
    bus_read(4, d); chk("R10 lock", d, 0);
    bus_read(1, d); chk("R10 status", d, 0);
  endtask

  task automatic t_reset_ctrl();
    logic [31:0] d;
    bus_write(0, 32'h5);
    chk("R1 not yet", 32'(core_rst), 0);
    @(negedge clk);
    chk("R1 core_rst", 32'(core_rst), 32'h5);
    bus_read(1, d); chk("R2 status lags", d, 0);
    bus_read(1, d); chk("R2 status set", d, 32'h5);
    bus_write(1, 32'h1);
    bus_read(1, d); chk("R2 w1c", d, 32'h4);
    bus_write(0, 32'h0);
    @(negedge clk); @(negedge clk);
    chk("R1 release", 32'(core_rst), 0);
    bus_read(1, d); chk("R2 status release", d, 0);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    core_busy = 4'b0010;
    bus_write(2, 32'h3);
    chk("R3 if_off", 32'(core_if_off), 32'h3);
    @(negedge clk);
    bus_read(3, d); chk("R4 drained busy", d, 32'h1);
    core_busy = 4'b0000;
    @(negedge clk);
    bus_read(3, d); chk("R4 drained all", d, 32'h3);
    bus_write(2, 32'h0);
    chk("R3 if_off clear", 32'(core_if_off), 0);
  endtask

  task automatic t_reenable_in_reset();
    logic [31:0] d;
    bus_write(0, 32'h1);
    bus_write(2, 32'h1);
    bus_write(2, 32'h0);
    chk("R5 if_off", 32'(core_if_off), 0);
    chk("R5 core_rst", 32'(core_rst), 32'h1);
    bus_read(0, d); chk("R5 ctrl", d, 32'h1);
    bus_write(0, 32'h0);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_width();
    logic [31:0] d;
    bus_write(0, 32'hFF);
    bus_read(0, d); chk("R9 upper bits", d, 32'h0F);
    bus_write(0, 32'h0);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_addr_err();
    logic [31:0] d;
    bus_write(3, 32'hF);
    chk("R6 irq", 32'(err_irq), 1);
    bus_read(5, d); chk("R6 flag", d, 32'h2);
    bus_read(3, d); chk("R6 drained unchanged", d, 0);
    bus_write(5, 32'h2);
    chk("R8 w1c irq", 32'(err_irq), 0);
    bus_read(7, d); chk("R6 rsvd data", d, 0);
    chk("R6 rsvd irq", 32'(err_irq), 1);
    bus_write(5, 32'h2);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    bus_write(4, 32'h1);
    bus_read(4, d); chk("R7 lock set", d, 32'h1);
    bus_write(0, 32'hF);
    chk("R7 irq", 32'(err_irq), 1);
    @(negedge clk);
    chk("R7 core_rst held", 32'(core_rst), 0);
    bus_read(5, d); chk("R7 write flag", d, 32'h1);
    bus_write(2, 32'hF);
    chk("R7 if_off held", 32'(core_if_off), 0);
    bus_write(4, 32'h0);
    bus_read(4, d); chk("R7 lock stays", d, 32'h1);
    bus_write(6, 32'h0);
    bus_read(5, d); chk("R8 both flags", d, 32'h3);
    bus_write(5, 32'h1);
    bus_read(5, d); chk("R8 one cleared", d, 32'h2);
    chk("R8 irq remains", 32'(err_irq), 1);
    bus_write(5, 32'h2);
    chk("R8 irq clear", 32'(err_irq), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; core_busy = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_reset_ctrl();
    t_disable();
    t_reenable_in_reset();
    t_width();
    t_addr_err();
    t_lock();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule